// File: doc/BRIEF.md
# Display Frame Timing Sequencer

This block produces the frame-level schedule for a renderer that takes over the system bus. A step timer divides qualified clock cycles into counter steps. A frame position counter walks through 65 positions per frame. A frame-skip divider chooses which frames may use the renderer. When a permitted frame reaches the start position for the selected mode, the block holds the CPU off the bus. It tells the render engine and then the copy engine when to begin. When the bus is released it raises completion interrupts.

The block does no rendering, memory access or LCD signalling. It only sets when those engines run. Every pin is plain control or status; there is no streaming interface, so no back-pressure applies. The render and copy engines must be ready for their one-cycle start strobes whenever these are issued. The mode is sampled once per window, so software may reprogram the mode while a window is active.

Top module: `frame_timing_seq`

## Requirements
- R1: `frame_pos` is 0x01 after reset. On each step it increments by one. From 0x41 it wraps to 0x01, so a frame has 65 positions.
- R2: A step occurs once every `STEP_CYCLES` cycles in which `tick` is high. While `tick` is low, `frame_pos` holds its value.
- R3: `rate_status[7:4]` holds the divider state and `rate_status[3:0]` echoes `rate_div`. The state is 0 after reset. It advances at every frame wrap and returns to 0 on the wrap after it has reached `rate_div`, giving a period of `rate_div`+1 frames.
- R4: A window may open only in a frame in which the divider state equals `rate_div`.
- R5: With `copy_en`=1 and `render_en`=1, `halt` rises and `render_start` pulses when `frame_pos` becomes 0x17. `copy_start` pulses when `frame_pos` becomes 0x38. `halt` falls when `frame_pos` becomes 0x03 in the next frame, after 45 steps.
- R6: With `copy_en`=1 and `render_en`=0, `halt` rises together with a `copy_start` pulse when `frame_pos` becomes 0x38. No `render_start` is issued, and `halt` lasts 12 steps.
- R7: With `copy_en`=0, no window opens and no strobe or interrupt is issued, whatever the value of `render_en`.
- R8: In every window, `irq_copy_done` pulses for one cycle when `frame_pos` wraps to 0x01. `irq_render_done` pulses for one cycle as `halt` falls at 0x03. Both pulses occur in copy-only mode as well.
- R9: `irq_flags[0]` latches `irq_render_done` and `irq_flags[1]` latches `irq_copy_done`. Writing a one on the matching bit of `flag_clr` clears that flag and leaves the other flag unchanged.
- R10: The mode is sampled when a window opens. Changing `copy_en` or `render_en` during a window does not change its strobes, its interrupts or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Cycle qualifier for the step timer |
| copy_en | input | 1 | Frame copy enable (also gates rendering) |
| render_en | input | 1 | Render stage enable |
| rate_div | input | 4 | Frame-skip divide value |
| flag_clr | input | 2 | Write-one-to-clear for the interrupt flags |
| frame_pos | output | 7 | Current frame position |
| rate_status | output | 8 | {divider state, rate_div} |
| render_start | output | 1 | One-cycle render engine start |
| copy_start | output | 1 | One-cycle copy engine start |
| halt | output | 1 | CPU halt / bus grant to the renderer |
| irq_render_done | output | 1 | One-cycle render-done interrupt |
| irq_copy_done | output | 1 | One-cycle frame-copied interrupt |
| irq_flags | output | 2 | Sticky interrupt flags {copy, render} |

## Verification
A corrupted position counter appears at `frame_pos` within one step. It also shifts or removes the `halt` edges within one frame. A stuck or miscounting divider shows in the upper nibble of `rate_status` at the next wrap, and as a wrong count of windows over a run of several frames. A wrong window state shows as a wrong `halt` length, measured in clocks. It also shows as a missing or extra start strobe or interrupt within the same window.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int POS_W = 7;
  localparam logic [POS_W-1:0] POS_FIRST   = 7'h01;
  localparam logic [POS_W-1:0] POS_LAST    = 7'h41;
  localparam logic [POS_W-1:0] POS_FULL_GO = 7'h17;
  localparam logic [POS_W-1:0] POS_COPY_GO = 7'h38;
  localparam logic [POS_W-1:0] POS_RELEASE = 7'h03;

  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_RENDER = 2'd1,
    WIN_COPY   = 2'd2
  } win_state_t;
endpackage

// File: rtl/fts_step_timer.sv
module fts_step_timer #(
  parameter int STEP_CYCLES = 855
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic step
);
  localparam int TW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [TW-1:0] LIMIT = TW'(STEP_CYCLES - 1);

  generate
    if (STEP_CYCLES <= 1) begin : g_direct
      assign step = tick;
    end else begin : g_count
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk) begin
        if (!rst_n)
          tcnt <= '0;
        else if (tick)
          tcnt <= (tcnt == LIMIT) ? '0 : tcnt + 1'b1;
      end
      assign step = tick && (tcnt == LIMIT);

      // R2
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tcnt));
    end
  endgenerate
endmodule

// File: rtl/fts_frame_counter.sv
module fts_frame_counter
  import fts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt,
  output logic             wrap
);
  always_comb begin
    pos_nxt = pos;
    if (step) pos_nxt = (pos == POS_LAST) ? POS_FIRST : pos + 1'b1;
  end
  assign wrap = step && (pos == POS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= POS_FIRST;
    else        pos <= pos_nxt;
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos >= POS_FIRST) && (pos <= POS_LAST));
  // R2
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos));
endmodule

// File: rtl/fts_rate_divider.sv
module fts_rate_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [DIV_W-1:0] rate_div,
  output logic [DIV_W-1:0] div_state,
  output logic             at_max
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      div_state <= '0;
    else if (wrap)
      div_state <= (div_state >= rate_div) ? '0 : div_state + 1'b1;
  end
  assign at_max = (div_state == rate_div);

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(div_state));
endmodule

// File: rtl/fts_window.sv
module fts_window
  import fts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [POS_W-1:0] pos_nxt,
  input  logic             at_max,
  input  logic             copy_en,
  input  logic             render_en,
  output logic             halt,
  output logic             render_start,
  output logic             copy_start,
  output logic             irq_render_done,
  output logic             irq_copy_done
);
  win_state_t state, state_nxt;
  logic rs_nxt, cs_nxt, ir_nxt, ic_nxt;

  always_comb begin
    state_nxt = state;
    rs_nxt = 1'b0;
    cs_nxt = 1'b0;
    ir_nxt = 1'b0;
    ic_nxt = 1'b0;
    if (step) begin
      unique case (state)
        WIN_IDLE: begin
          if (at_max && copy_en) begin
            if (render_en && pos_nxt == POS_FULL_GO) begin
              state_nxt = WIN_RENDER;
              rs_nxt    = 1'b1;
            end else if (!render_en && pos_nxt == POS_COPY_GO) begin
              state_nxt = WIN_COPY;
              cs_nxt    = 1'b1;
            end
          end
        end
        WIN_RENDER: begin
          if (pos_nxt == POS_COPY_GO) begin
            state_nxt = WIN_COPY;
            cs_nxt    = 1'b1;
          end
        end
        WIN_COPY: begin
          if (pos_nxt == POS_FIRST) ic_nxt = 1'b1;
          if (pos_nxt == POS_RELEASE) begin
            state_nxt = WIN_IDLE;
            ir_nxt    = 1'b1;
          end
        end
        default: state_nxt = WIN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= WIN_IDLE;
      render_start    <= 1'b0;
      copy_start      <= 1'b0;
      irq_render_done <= 1'b0;
      irq_copy_done   <= 1'b0;
    end else begin
      state           <= state_nxt;
      render_start    <= rs_nxt;
      copy_start      <= cs_nxt;
      irq_render_done <= ir_nxt;
      irq_copy_done   <= ic_nxt;
    end
  end

  assign halt = (state != WIN_IDLE);

  // R5
  open_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> (render_start || copy_start));
  // R8
  close_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |-> irq_render_done);
  // R8
  render_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_render_done |=> !irq_render_done);
  // R8
  copy_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_copy_done |=> !irq_copy_done);
  // R5
  strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (render_start || copy_start) |-> halt);
endmodule

// File: rtl/frame_timing_seq.sv
module frame_timing_seq
  import fts_pkg::*;
#(
  parameter int STEP_CYCLES = 855,
  parameter int DIV_W       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               copy_en,
  input  logic               render_en,
  input  logic [DIV_W-1:0]   rate_div,
  input  logic [1:0]         flag_clr,
  output logic [POS_W-1:0]   frame_pos,
  output logic [2*DIV_W-1:0] rate_status,
  output logic               render_start,
  output logic               copy_start,
  output logic               halt,
  output logic               irq_render_done,
  output logic               irq_copy_done,
  output logic [1:0]         irq_flags
);
  logic             step, wrap, at_max;
  logic [POS_W-1:0] pos_nxt;
  logic [DIV_W-1:0] div_state;

  fts_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step));

  fts_frame_counter u_pos (
    .clk(clk), .rst_n(rst_n), .step(step),
    .pos(frame_pos), .pos_nxt(pos_nxt), .wrap(wrap));

  fts_rate_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .rate_div(rate_div),
    .div_state(div_state), .at_max(at_max));

  fts_window u_win (
    .clk(clk), .rst_n(rst_n), .step(step), .pos_nxt(pos_nxt),
    .at_max(at_max), .copy_en(copy_en), .render_en(render_en),
    .halt(halt), .render_start(render_start), .copy_start(copy_start),
    .irq_render_done(irq_render_done), .irq_copy_done(irq_copy_done));

  assign rate_status = {div_state, rate_div};

  always_ff @(posedge clk) begin
    if (!rst_n) irq_flags <= '0;
    else        irq_flags <= (irq_flags & ~flag_clr) | {irq_copy_done, irq_render_done};
  end

  // R9
  render_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_render_done |=> irq_flags[0]);
  // R9
  copy_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_copy_done |=> irq_flags[1]);
endmodule

// File: tb/frame_timing_seq_test.sv
`timescale 1ns/1ps
module frame_timing_seq_test;
  localparam int S = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, copy_en = 1'b0, render_en = 1'b0;
  logic [3:0] rate_div = '0;
  logic [1:0] flag_clr = '0;
  logic [6:0] frame_pos;
  logic [7:0] rate_status;
  logic render_start, copy_start, halt, irq_render_done, irq_copy_done;
  logic [1:0] irq_flags;

  int checks = 0, failures = 0;
  int n_win, n_rs, n_cs, n_ir, n_ic, halt_clks, first_pos, max_pos, min_pos;
  logic prev_halt;
  logic mon_on = 1'b0;

  always #4 clk = ~clk;

  frame_timing_seq #(.STEP_CYCLES(S), .DIV_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .copy_en(copy_en), .render_en(render_en),
    .rate_div(rate_div), .flag_clr(flag_clr), .frame_pos(frame_pos),
    .rate_status(rate_status), .render_start(render_start), .copy_start(copy_start),
    .halt(halt), .irq_render_done(irq_render_done), .irq_copy_done(irq_copy_done),
    .irq_flags(irq_flags));

  always @(negedge clk) begin
    if (mon_on) begin
      if (halt && !prev_halt) begin
        if (n_win == 0) first_pos = int'(frame_pos);
        n_win++;
      end
      if (halt) halt_clks++;
      if (render_start) n_rs++;
      if (copy_start) n_cs++;
      if (irq_render_done) n_ir++;
      if (irq_copy_done) n_ic++;
      if (int'(frame_pos) > max_pos) max_pos = int'(frame_pos);
      if (int'(frame_pos) < min_pos) min_pos = int'(frame_pos);
      prev_halt = halt;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mon_on = 1'b0;
    n_win = 0; n_rs = 0; n_cs = 0; n_ir = 0; n_ic = 0; halt_clks = 0;
    first_pos = -1; max_pos = 0; min_pos = 1000; prev_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mon_on = 1'b1;
  endtask

  typedef struct packed {
    logic       c;
    logic       r;
    logic [3:0] rate;
    logic [7:0] frames;
  } vec_t;

  localparam vec_t VECS[6] = '{
    '{1'b1, 1'b1, 4'd0, 8'd3},
    '{1'b1, 1'b0, 4'd0, 8'd3},
    '{1'b0, 1'b1, 4'd0, 8'd3},
    '{1'b1, 1'b1, 4'd2, 8'd6},
    '{1'b1, 1'b0, 4'd1, 8'd4},
    '{1'b0, 1'b0, 4'd0, 8'd2}
  };

  initial begin
    #(200000 * 8);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state: R1, R3, R9
    rate_div = 4'd2;
    do_reset();
    chk(frame_pos == 7'h01, "R1 reset position", int'(frame_pos), 1);
    chk(rate_status == 8'h02, "R3 reset rate status", int'(rate_status), 8'h02);
    chk(halt == 1'b0, "R7 reset halt", int'(halt), 0);
    chk(irq_flags == 2'b00, "R9 reset flags", int'(irq_flags), 0);

    // divider advances after one frame: R3
    repeat (65 * S + 1) @(negedge clk);
    chk(rate_status == 8'h12, "R3 divider after one frame", int'(rate_status), 8'h12);

    // tick gating: R2
    do_reset();
    tick = 1'b0;
    repeat (20) @(negedge clk);
    chk(frame_pos == 7'h01, "R2 hold without tick", int'(frame_pos), 1);
    tick = 1'b1;
    repeat (2 * S) @(negedge clk);
    chk(frame_pos == 7'h03, "R2 steps with tick", int'(frame_pos), 3);

    // table of mode / rate vectors: R4..R8, R1
    for (int i = 0; i < 6; i++) begin
      int exp_win, exp_steps, exp_pos;
      copy_en = VECS[i].c;
      render_en = VECS[i].r;
      rate_div = VECS[i].rate;
      do_reset();
      repeat (int'(VECS[i].frames) * 65 * S + 3 * S) @(negedge clk);
      exp_win = VECS[i].c ? int'(VECS[i].frames) / (int'(VECS[i].rate) + 1) : 0;
      exp_steps = VECS[i].r ? 45 : 12;
      exp_pos = VECS[i].r ? 8'h17 : 8'h38;
      chk(n_win == exp_win, "R4 window count", n_win, exp_win);
      chk(n_cs == exp_win, "R5 R6 R7 copy starts", n_cs, exp_win);
      chk(n_rs == (VECS[i].r ? exp_win : 0), "R5 R6 render starts", n_rs,
          VECS[i].r ? exp_win : 0);
      chk(n_ir == exp_win, "R8 render-done irqs", n_ir, exp_win);
      chk(n_ic == exp_win, "R8 copy-done irqs", n_ic, exp_win);
      chk(halt_clks == exp_win * exp_steps * S, "R5 R6 halt length", halt_clks,
          exp_win * exp_steps * S);
      if (exp_win > 0) begin
        chk(first_pos == exp_pos, "R5 R6 open position", first_pos, exp_pos);
        chk(irq_flags == 2'b11, "R9 flags latched", int'(irq_flags), 3);
      end
      chk(max_pos == 8'h41 && min_pos == 1, "R1 position range", max_pos, 8'h41);
    end

    // W1C: R9
    copy_en = 1'b1; render_en = 1'b0; rate_div = 4'd0;
    do_reset();
    repeat (65 * S + 3 * S) @(negedge clk);
    chk(irq_flags == 2'b11, "R9 flags before clear", int'(irq_flags), 3);
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    chk(irq_flags == 2'b10, "R9 clear render flag only", int'(irq_flags), 2);
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 2'b00;
    chk(irq_flags == 2'b00, "R9 clear copy flag", int'(irq_flags), 0);

    // mode change inside a window: R10
    copy_en = 1'b1; render_en = 1'b1; rate_div = 4'd0;
    do_reset();
    for (int k = 0; k < 65 * S && !halt; k++) @(negedge clk);
    copy_en = 1'b0; render_en = 1'b0;
    repeat (65 * S + 3 * S) @(negedge clk);
    chk(n_win == 1, "R10 single window", n_win, 1);
    chk(n_cs == 1, "R10 copy start kept", n_cs, 1);
    chk(n_ir == 1 && n_ic == 1, "R10 irqs kept", n_ir + n_ic, 2);
    chk(halt_clks == 45 * S, "R10 window length kept", halt_clks, 45 * S);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule